// File: doc/BRIEF.md
# Masked Lane Reset Stretcher

This block turns a software reset request into per-lane reset pulses for a group of data lanes and one tristate lane. Each reset is guaranteed a minimum length: one control-clock period followed by a count of fast-clock cycles. That count grows with the configured serialization width. The block runs entirely in the fast clock domain. The control clock enters as a one-cycle enable, `ctrl_ce`, and requests are sampled only in cycles where it is high.

A mask picks the data lanes that take part in a reset. The tristate lane has its own request and its own mask bit. The mask is captured when the request is accepted.

While a lane is held in reset, its transmit output carries that lane's initial value. Once the lane is released, the output returns to the live transmit data immediately. A per-lane receive qualifier reports the first moment after a lane reset when the receive FIFO stops being empty. A protocol flag marks read or write enables that are high when they must be low.

Top module: `lane_rst_stretch`

## Requirements
- R1: When bit x of `lane_mask` is 1 in the cycle a data request is accepted, data lane x is not reset by that request. The mask is captured at acceptance, so later changes to it have no effect on a reset in progress.
- R2: A request is accepted on a `ctrl_ce` cycle in which the request is high and the channel is idle. The reset outputs rise on that edge. They stay high for one control period plus N fast cycles when the request is cleared before the next `ctrl_ce`. N = 8*B + 8, where B is taken from `wsel`: 2'b00 gives 2, 2'b01 gives 4, and 2'b10 or 2'b11 gives 8. This makes N 24, 40 or 72.
- R3: If the request is still high when the minimum expires, reset stays asserted. It is released on the first `ctrl_ce` edge that samples the request low.
- R4: A data lane in reset drives `tx_out` to its `tx_init` bit. A lane that is not in reset drives a one-cycle registered copy of `tx_data`. This includes the first cycle after release.
- R5: The tristate lane behaves like a data lane, with the same timing, but uses its own request `tri_req`, mask `tri_mask` (1 = excluded), initial value `tri_init` and data `tri_data`. It never resets data lanes.
- R6: A lane reset clears that lane's `rx_valid`. After release, `rx_valid` sets on the first cycle in which `fifo_empty` is low, provided it was seen high since the release. Lanes that were not reset keep their `rx_valid`.
- R7: `proto_err` is high for the cycle after any edge where a channel accepts a request or is busy, while the enables that channel forbids are high. For the data channel these are `rd_en` or `wr_en`; for the tristate channel it is `wr_en`.
- R8: After block reset, all reset outputs, `tx_out`, `tri_out`, `rx_valid` and `proto_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high block reset |
| ctrl_ce | input | 1 | One-cycle enable marking each control-clock edge |
| wsel | input | 2 | Serialization width select |
| rst_req | input | 1 | Data-lane reset request level |
| tri_req | input | 1 | Tristate-lane reset request level |
| lane_mask | input | LANES | 1 excludes the data lane from reset |
| tri_mask | input | 1 | 1 excludes the tristate lane from reset |
| tx_init | input | LANES | Per-lane transmit value during reset |
| tri_init | input | 1 | Tristate value during reset |
| tx_data | input | LANES | Live transmit data |
| tri_data | input | 1 | Live tristate control |
| rd_en | input | 1 | Read enable observed for protocol checking |
| wr_en | input | 1 | Write enable observed for protocol checking |
| fifo_empty | input | LANES | Per-lane receive FIFO empty indication |
| lane_rst | output | LANES | Per-lane data reset |
| tri_rst | output | 1 | Tristate lane reset |
| tx_out | output | LANES | Per-lane transmit output |
| tri_out | output | 1 | Tristate output |
| rx_valid | output | LANES | Receive data valid per lane |
| proto_err | output | 1 | Enable protocol violation flag |

## Verification
Four properties are checked on every cycle:
- a masked lane never rises into reset;
- a data pulse is never shorter than the smallest legal minimum;
- any lane in reset carries its initial value and shows no valid receive data;
- a reset started with enables high is flagged.

The exact pulse lengths for each width select are left to the bench's scenarios. So are the extension of a held request to the next control edge, the capture of the mask at acceptance, the FIFO-empty qualification sequence and the independence of the tristate channel.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int LRS_TAPS_PER_BIT = 8;
  localparam int LRS_TAPS_BASE    = 8;
  localparam int LRS_MAX_BITS     = 8;
  localparam int LRS_MAX_COUNT    = LRS_TAPS_PER_BIT * LRS_MAX_BITS + LRS_TAPS_BASE;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_COUNT,
    ST_HOLD
  } lrs_state_e;

  // Fast-cycle part of the minimum reset length for a width select.
  function automatic int lrs_fast_count(input logic [1:0] sel);
    int bits;
    case (sel)
      2'b00:   bits = 2;
      2'b01:   bits = 4;
      default: bits = LRS_MAX_BITS;
    endcase
    return LRS_TAPS_PER_BIT * bits + LRS_TAPS_BASE;
  endfunction
endpackage

// File: rtl/lrs_stretch.sv
module lrs_stretch
  import lrs_pkg::*;
#(
  parameter int LANES = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_ce,
  input  logic             req,
  input  logic [1:0]       wsel,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] rst_nxt,
  output logic [LANES-1:0] rst_q,
  output logic             busy,
  output logic             start
);
  lrs_state_e       st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [LANES-1:0] lanes, lanes_n;
  logic [1:0]       wsel_q, wsel_n;
  logic             req_s;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    lanes_n = lanes;
    wsel_n  = wsel_q;
    start   = 1'b0;
    case (st)
      ST_IDLE: begin
        if (ctrl_ce && req) begin
          start   = 1'b1;
          st_n    = ST_ARM;
          lanes_n = ~mask;
          wsel_n  = wsel;
        end
      end
      ST_ARM: begin
        // one full control period has passed at the next control edge
        if (ctrl_ce) begin
          st_n  = ST_COUNT;
          cnt_n = CNT_W'(lrs_fast_count(wsel_q) - 1);
        end
      end
      ST_COUNT: begin
        if (cnt == '0) st_n = req_s ? ST_HOLD : ST_IDLE;
        else           cnt_n = cnt - CNT_W'(1);
      end
      ST_HOLD: begin
        if (ctrl_ce && !req) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    rst_nxt = (st_n != ST_IDLE) ? lanes_n : '0;
  end

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      lanes  <= '0;
      wsel_q <= 2'b00;
      req_s  <= 1'b0;
      rst_q  <= '0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      lanes  <= lanes_n;
      wsel_q <= wsel_n;
      if (ctrl_ce) req_s <= req;
      rst_q  <= rst_nxt;
    end
  end
endmodule

// File: rtl/lrs_txsel.sv
module lrs_txsel #(
  parameter int LANES = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] force_i,
  input  logic [LANES-1:0] init_i,
  input  logic [LANES-1:0] data_i,
  output logic [LANES-1:0] out_q
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)             out_q[i] <= 1'b0;
      else if (force_i[i]) out_q[i] <= init_i[i];
      else                 out_q[i] <= data_i[i];
    end
  end
endmodule

// File: rtl/lrs_rxqual.sv
module lrs_rxqual #(
  parameter int LANES = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lane_rst_nxt,
  input  logic [LANES-1:0] fifo_empty,
  output logic [LANES-1:0] valid_q
);
  logic [LANES-1:0] armed;
  logic [LANES-1:0] seen_empty;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[i]    <= 1'b0;
        armed[i]      <= 1'b0;
        seen_empty[i] <= 1'b0;
      end else if (lane_rst_nxt[i]) begin
        valid_q[i]    <= 1'b0;
        armed[i]      <= 1'b1;
        seen_empty[i] <= 1'b0;
      end else if (armed[i]) begin
        if (fifo_empty[i]) begin
          seen_empty[i] <= 1'b1;
        end else if (seen_empty[i]) begin
          // first empty-to-nonempty transition since release (R6)
          valid_q[i] <= 1'b1;
          armed[i]   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/lane_rst_stretch.sv
module lane_rst_stretch
  import lrs_pkg::*;
#(
  parameter int LANES = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_ce,
  input  logic [1:0]       wsel,
  input  logic             rst_req,
  input  logic             tri_req,
  input  logic [LANES-1:0] lane_mask,
  input  logic             tri_mask,
  input  logic [LANES-1:0] tx_init,
  input  logic             tri_init,
  input  logic [LANES-1:0] tx_data,
  input  logic             tri_data,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [LANES-1:0] fifo_empty,
  output logic [LANES-1:0] lane_rst,
  output logic             tri_rst,
  output logic [LANES-1:0] tx_out,
  output logic             tri_out,
  output logic [LANES-1:0] rx_valid,
  output logic             proto_err
);
  localparam int CNT_W = $clog2(LRS_MAX_COUNT + 1);

  logic [LANES-1:0] d_nxt;
  logic             d_busy, d_start;
  logic [0:0]       t_nxt, t_q;
  logic             t_busy, t_start;

  lrs_stretch #(.LANES(LANES), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rst(rst), .ctrl_ce(ctrl_ce), .req(rst_req), .wsel(wsel),
    .mask(lane_mask), .rst_nxt(d_nxt), .rst_q(lane_rst),
    .busy(d_busy), .start(d_start)
  );

  lrs_stretch #(.LANES(1), .CNT_W(CNT_W)) u_tri (
    .clk(clk), .rst(rst), .ctrl_ce(ctrl_ce), .req(tri_req), .wsel(wsel),
    .mask(tri_mask), .rst_nxt(t_nxt), .rst_q(t_q),
    .busy(t_busy), .start(t_start)
  );

  assign tri_rst = t_q[0];

  lrs_txsel #(.LANES(LANES)) u_txd (
    .clk(clk), .rst(rst), .force_i(d_nxt), .init_i(tx_init),
    .data_i(tx_data), .out_q(tx_out)
  );

  logic [0:0] tri_out_q;
  lrs_txsel #(.LANES(1)) u_txt (
    .clk(clk), .rst(rst), .force_i(t_nxt), .init_i(tri_init),
    .data_i(tri_data), .out_q(tri_out_q)
  );
  assign tri_out = tri_out_q[0];

  lrs_rxqual #(.LANES(LANES)) u_rxq (
    .clk(clk), .rst(rst), .lane_rst_nxt(d_nxt),
    .fifo_empty(fifo_empty), .valid_q(rx_valid)
  );

  // R7: enables must stay low around a reset of the matching channel
  always_ff @(posedge clk) begin
    if (rst) proto_err <= 1'b0;
    else     proto_err <= ((d_start | d_busy) & (rd_en | wr_en)) |
                          ((t_start | t_busy) & wr_en);
  end
endmodule

// File: rtl/lrs_chk.sv
module lrs_chk
  import lrs_pkg::*;
#(
  parameter int LANES = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] lane_mask,
  input logic [LANES-1:0] tx_init,
  input logic             tri_init,
  input logic             rd_en,
  input logic             wr_en,
  input logic [LANES-1:0] lane_rst,
  input logic             tri_rst,
  input logic [LANES-1:0] tx_out,
  input logic             tri_out,
  input logic [LANES-1:0] rx_valid,
  input logic             proto_err
);
  localparam int MIN_HI = lrs_fast_count(2'b00) + 1;

  logic [15:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst)            hi_cnt <= '0;
    else if (|lane_rst) hi_cnt <= hi_cnt + 16'd1;
    else                hi_cnt <= '0;
  end

  p_mask_r1: assert property (@(posedge clk) disable iff (rst)
    (lane_rst & ~$past(lane_rst) & $past(lane_mask)) == '0);

  p_minlen_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(|lane_rst) && !$past(rst)) |-> hi_cnt >= 16'(MIN_HI));

  p_txinit_r4: assert property (@(posedge clk) disable iff (rst)
    ((tx_out ^ $past(tx_init)) & lane_rst) == '0);

  p_triinit_r5: assert property (@(posedge clk) disable iff (rst)
    tri_rst |-> tri_out == $past(tri_init));

  p_rxclr_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid & lane_rst) == '0);

  p_err_r7: assert property (@(posedge clk) disable iff (rst)
    (($rose(|lane_rst) && $past(rd_en | wr_en)) ||
     ($rose(tri_rst) && $past(wr_en))) |-> proto_err);
endmodule

bind lane_rst_stretch lrs_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .lane_mask(lane_mask), .tx_init(tx_init),
  .tri_init(tri_init), .rd_en(rd_en), .wr_en(wr_en), .lane_rst(lane_rst),
  .tri_rst(tri_rst), .tx_out(tx_out), .tri_out(tri_out),
  .rx_valid(rx_valid), .proto_err(proto_err)
);

// File: tb/sim_lane_rst_stretch.sv
module sim_lane_rst_stretch;
  localparam int CLK_NS = 10;
  localparam int NL     = 6;
  localparam int CTRL_P = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] div = 2'd0;
  logic ctrl_ce;
  logic [1:0] wsel = 2'b00;
  logic rst_req = 1'b0, tri_req = 1'b0;
  logic [NL-1:0] lane_mask = '0, tx_init = '0, tx_data = '0;
  logic [NL-1:0] fifo_empty = '1;
  logic tri_mask = 1'b0, tri_init = 1'b0, tri_data = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [NL-1:0] lane_rst, tx_out, rx_valid;
  logic tri_rst, tri_out, proto_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) div <= div + 2'd1;
  assign ctrl_ce = (div == 2'd3);

  lane_rst_stretch #(.LANES(NL)) u0 (
    .clk(clk), .rst(rst), .ctrl_ce(ctrl_ce), .wsel(wsel),
    .rst_req(rst_req), .tri_req(tri_req), .lane_mask(lane_mask),
    .tri_mask(tri_mask), .tx_init(tx_init), .tri_init(tri_init),
    .tx_data(tx_data), .tri_data(tri_data), .rd_en(rd_en), .wr_en(wr_en),
    .fifo_empty(fifo_empty), .lane_rst(lane_rst), .tri_rst(tri_rst),
    .tx_out(tx_out), .tri_out(tri_out), .rx_valid(rx_valid),
    .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int exp_width(input logic [1:0] s);
    int b;
    b = (s == 2'b00) ? 2 : (s == 2'b01) ? 4 : 8;
    return CTRL_P + 8 * b + 8;
  endfunction

  // Stop at a falling edge whose next rising edge is a control edge.
  task automatic wait_ctrl();
    do @(negedge clk); while (!ctrl_ce);
  endtask

  // Raise a request for exactly one control sample; returns at the
  // falling edge after the accepting edge.
  task automatic fire(input bit tri_sel);
    wait_ctrl();
    if (tri_sel) tri_req = 1'b1; else rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    tri_req = 1'b0;
  endtask

  task automatic measure(input bit tri_sel, output int w, output logic [NL-1:0] seen,
                         output bit err_seen);
    w = 0; seen = '0; err_seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      logic on;
      on = tri_sel ? tri_rst : |lane_rst;
      seen |= lane_rst;
      err_seen |= proto_err;
      if (!on) break;
      w++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(lane_rst == '0 && tri_rst == 1'b0, "R8 reset outputs", int'(lane_rst), 0);
    chk(tx_out == '0 && tri_out == 1'b0, "R8 tx outputs", int'(tx_out), 0);
    chk(rx_valid == '0 && proto_err == 1'b0, "R8 rx/err", int'(rx_valid), 0);
  endtask

  task automatic t_widths();
    int w; logic [NL-1:0] s; bit e;
    for (int k = 0; k < 4; k++) begin
      wsel = 2'(k);
      fire(1'b0);
      measure(1'b0, w, s, e);
      chk(w == exp_width(wsel), "R2 pulse width", w, exp_width(wsel));
    end
  endtask

  task automatic t_mask();
    int w; logic [NL-1:0] s; bit e;
    wsel = 2'b01;
    lane_mask = 6'b101010;
    fire(1'b0);
    chk(lane_rst == 6'b010101, "R1 masked set", int'(lane_rst), 6'b010101);
    lane_mask = 6'b111111;
    @(negedge clk);
    chk(lane_rst == 6'b010101, "R1 mask captured", int'(lane_rst), 6'b010101);
    measure(1'b0, w, s, e);
    chk(s == 6'b010101, "R1 lanes ever reset", int'(s), 6'b010101);
    lane_mask = '0;
  endtask

  task automatic t_tx();
    int w; logic [NL-1:0] s; bit e;
    wsel = 2'b00;
    tx_init = 6'b110011;
    tx_data = 6'b001010;
    lane_mask = 6'b000011;
    fire(1'b0);
    @(negedge clk);
    chk(tx_out == 6'b110010, "R4 forced init", int'(tx_out), 6'b110010);
    measure(1'b0, w, s, e);
    chk(tx_out == 6'b001010, "R4 data after release", int'(tx_out), 6'b001010);
    tx_data = 6'b010101;
    @(negedge clk);
    chk(tx_out == 6'b010101, "R4 data follows", int'(tx_out), 6'b010101);
    lane_mask = '0;
  endtask

  task automatic t_hold();
    wsel = 2'b10;
    wait_ctrl();
    rst_req = 1'b1;
    repeat (120) @(negedge clk);
    chk(lane_rst == 6'h3f, "R3 held past minimum", int'(lane_rst), 6'h3f);
    wait_ctrl();
    rst_req = 1'b0;
    chk(lane_rst == 6'h3f, "R3 before control edge", int'(lane_rst), 6'h3f);
    @(negedge clk);
    chk(lane_rst == '0, "R3 released at control edge", int'(lane_rst), 0);
  endtask

  task automatic t_tri();
    int w; logic [NL-1:0] s; bit e;
    wsel = 2'b01;
    tri_mask = 1'b0;
    tri_init = 1'b1;
    tri_data = 1'b0;
    fire(1'b1);
    chk(tri_out == 1'b1, "R5 tri init", int'(tri_out), 1);
    chk(lane_rst == '0, "R5 data lanes untouched", int'(lane_rst), 0);
    measure(1'b1, w, s, e);
    chk(w == exp_width(wsel), "R5 tri width", w, exp_width(wsel));
    chk(s == '0, "R5 no data reset", int'(s), 0);
    tri_mask = 1'b1;
    fire(1'b1);
    chk(tri_rst == 1'b0, "R5 tri masked", int'(tri_rst), 0);
    chk(tri_out == 1'b0, "R5 tri data passes", int'(tri_out), 0);
    tri_mask = 1'b0;
  endtask

  task automatic t_rx();
    int w; logic [NL-1:0] s; bit e;
    wsel = 2'b00;
    fifo_empty = '1;
    lane_mask = '0;
    fire(1'b0);
    chk(rx_valid == '0, "R6 cleared in reset", int'(rx_valid), 0);
    measure(1'b0, w, s, e);
    @(negedge clk);
    chk(rx_valid == '0, "R6 empty after release", int'(rx_valid), 0);
    fifo_empty = 6'h3e;
    @(negedge clk);
    chk(rx_valid == 6'h01, "R6 first lane valid", int'(rx_valid), 1);
    fifo_empty = '0;
    @(negedge clk);
    chk(rx_valid == 6'h3f, "R6 all lanes valid", int'(rx_valid), 6'h3f);
    lane_mask = 6'h01;
    fifo_empty = '1;
    fire(1'b0);
    measure(1'b0, w, s, e);
    chk(rx_valid == 6'h01, "R6 masked lane kept", int'(rx_valid), 1);
    lane_mask = '0;
    fifo_empty = '0;
  endtask

  task automatic t_err();
    int w; logic [NL-1:0] s; bit e;
    wsel = 2'b00;
    rd_en = 1'b1;
    fire(1'b0);
    chk(proto_err == 1'b1, "R7 read enable at request", int'(proto_err), 1);
    rd_en = 1'b0;
    @(negedge clk);
    measure(1'b0, w, s, e);
    chk(e == 1'b0, "R7 quiet after enables low", int'(e), 0);
    fire(1'b0);
    measure(1'b0, w, s, e);
    chk(e == 1'b0, "R7 clean reset no flag", int'(e), 0);
    fire(1'b0);
    wr_en = 1'b1;
    @(negedge clk);
    chk(proto_err == 1'b1, "R7 enable during reset", int'(proto_err), 1);
    wr_en = 1'b0;
    @(negedge clk);
    measure(1'b0, w, s, e);
    wr_en = 1'b1;
    fire(1'b1);
    chk(proto_err == 1'b1, "R7 write enable at tri request", int'(proto_err), 1);
    wr_en = 1'b0;
    @(negedge clk);
    measure(1'b1, w, s, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_widths();
    t_mask();
    t_tx();
    t_hold();
    t_tri();
    t_rx();
    t_err();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule